// File: doc/BRIEF.md
# Set/Clear Register GPIO Controller

This block controls thirty-two general-purpose pins, split into a low bank (pins 0 to 15) and a high bank (pins 16 to 31). The high bank's registers sit at a fixed address offset of 0x80 above the low bank's registers. Each bank holds eight per-pin control registers:

- output value
- output enable
- open-drain enable
- input enable
- input invert
- output invert
- pull-up enable
- pull-down enable

Each bank also has one read-only input readback register.

Software changes any pin's control bit with a single 32-bit write. The low half of the write data sets bits and the high half clears them, so no read-modify-write sequence is needed and a write cannot disturb a pin it does not name.

The pin datapath inverts the stored output value when output invert is set. It either drives the pad (push-pull) or only pulls it low (open-drain), and it forwards the pull controls. Pad inputs pass through a two-flop synchronizer and the input-invert control, and they are gated by input enable before they reach the readback register. All pad outputs are registered.

Top module: `pinbank_gpio`

## Requirements
- R1: After reset every control bit is zero: pad_oe, pad_out, pad_pu and pad_pd are all zero, and every register reads 0.
- R2: A write to a control register with a one in data bit n (n in 0..15) sets control bit n of that register and leaves the others unchanged. The word offsets are: output value 0x00, output enable 0x04, open-drain 0x08, input enable 0x0C, input invert 0x10, output invert 0x14, pull-up 0x18, pull-down 0x1C.
- R3: A one in data bit n+16 of a write clears control bit n of the addressed register.
- R4: When a write has both bit n and bit n+16 set, control bit n ends cleared.
- R5: Address bit 7 (offset 0x80) selects the high bank, where control bit n belongs to pin 16+n. Writes to one bank never change the other bank.
- R6: A read returns its data one cycle after rd_en, with rd_valid high in that cycle. The data holds the 16 bits of the addressed bank in bits 15:0 and zeros in bits 31:16.
- R7: The pad registers update on the clock edge after a control change. With open-drain off, pad_out equals output value XOR output invert and pad_oe equals output enable.
- R8: With open-drain on, pad_out is 0 and pad_oe is output enable AND NOT (output value XOR output invert).
- R9: Readback offset 0x20 returns, for each pin, input enable AND (synchronized pad_in XOR input invert). A pad change is invisible to a read issued on the next cycle; it appears after the two synchronizer flops and one output register.
- R10: pad_pu and pad_pd follow the pull-up and pull-down control bits of each pin.
- R11: The following writes change no state and reads of them return 0: writes to the readback offset, to offsets above 0x20 within a bank, to any address with bits 1:0 nonzero, or to any address above bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one 32-bit write per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data: set mask in 15:0, clear mask in 31:16 |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | High in the cycle rdata holds a read result |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Pad output level |
| pad_oe | output | 32 | Pad output driver enable |
| pad_pu | output | 32 | Pad pull-up enable |
| pad_pd | output | 32 | Pad pull-down enable |

## Verification
The assertions take for granted that wr_en and rd_en are never asserted in the same cycle, since the register interface issues one access at a time. They also assume reset is held from time zero until the first clock edge.

The directed stimulus issues every access as its own strobe pulse, launched from the falling edge, and never overlaps a read with a write. Raw pad inputs are changed only on falling edges, well away from the sampling edge. This keeps each synchronizer-latency check deterministic.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int NUM_CTL = 8;

  typedef enum logic [3:0] {
    CTL_OVAL = 4'd0,
    CTL_OE   = 4'd1,
    CTL_OD   = 4'd2,
    CTL_IE   = 4'd3,
    CTL_IINV = 4'd4,
    CTL_OINV = 4'd5,
    CTL_PU   = 4'd6,
    CTL_PD   = 4'd7,
    CTL_INRD = 4'd8,
    CTL_NONE = 4'd15
  } ctl_sel_e;

  typedef struct packed {
    logic     hit;
    logic     high;
    ctl_sel_e sel;
  } dec_t;
endpackage

// File: rtl/gpb_regdec.sv
module gpb_regdec #(
  parameter int ADDR_W   = 8,
  parameter int HIGH_BIT = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output gpb_pkg::dec_t     dec
);
  import gpb_pkg::*;
  localparam int IDX_W   = HIGH_BIT - 2;
  localparam int LAST_IX = 8;

  logic [IDX_W-1:0] idx;
  logic             upper_zero;

  always_comb begin
    idx        = addr[HIGH_BIT-1:2];
    upper_zero = 1'b1;
    for (int b = HIGH_BIT + 1; b < ADDR_W; b++) begin
      if (addr[b]) upper_zero = 1'b0;
    end
    dec.high = addr[HIGH_BIT];
    dec.hit  = upper_zero && (addr[1:0] == 2'b00) && (idx <= IDX_W'(LAST_IX));
    dec.sel  = dec.hit ? ctl_sel_e'(idx[3:0]) : CTL_NONE;
  end
endmodule

// File: rtl/gpb_bank.sv
module gpb_bank #(
  parameter int BANK_W = 16
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      we,
  input  gpb_pkg::ctl_sel_e                         sel,
  input  logic [2*BANK_W-1:0]                       wdata,
  output logic [gpb_pkg::NUM_CTL-1:0][BANK_W-1:0]   ctl_q
);
  import gpb_pkg::*;

  logic [BANK_W-1:0] set_m, clr_m;
  assign set_m = wdata[BANK_W-1:0];
  assign clr_m = wdata[2*BANK_W-1:BANK_W];

  // Clear is applied after set, so clear wins on a collision.
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else begin
      for (int c = 0; c < NUM_CTL; c++) begin
        if (we && (sel == ctl_sel_e'(c))) begin
          ctl_q[c] <= (ctl_q[c] | set_m) & ~clr_m;
        end
      end
    end
  end
endmodule

// File: rtl/gpb_pin.sv
module gpb_pin (
  input  logic clk,
  input  logic rst,
  input  logic oval,
  input  logic oe,
  input  logic od,
  input  logic ie,
  input  logic iinv,
  input  logic oinv,
  input  logic pu,
  input  logic pd,
  input  logic pad_in,
  output logic pad_out,
  output logic pad_oe,
  output logic pad_pu,
  output logic pad_pd,
  output logic in_val
);
  logic drive_v;
  logic sync1, sync2;

  assign drive_v = oval ^ oinv;

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
      pad_pu  <= 1'b0;
      pad_pd  <= 1'b0;
      sync1   <= 1'b0;
      sync2   <= 1'b0;
      in_val  <= 1'b0;
    end else begin
      pad_out <= od ? 1'b0 : drive_v;
      pad_oe  <= oe & ~(od & drive_v);
      pad_pu  <= pu;
      pad_pd  <= pd;
      sync1   <= pad_in;
      sync2   <= sync1;
      in_val  <= ie & (sync2 ^ iinv);
    end
  end
endmodule

// File: rtl/pinbank_gpio.sv
module pinbank_gpio #(
  parameter int BANK_W   = 16,
  parameter int ADDR_W   = 8,
  parameter int HIGH_BIT = 7,
  parameter int NPINS    = 2 * BANK_W,
  parameter int DATA_W   = 2 * BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pu,
  output logic [NPINS-1:0]  pad_pd
);
  import gpb_pkg::*;
  localparam int NBANK = 2;

  dec_t dec;
  logic [NUM_CTL-1:0][NPINS-1:0] ctl_all;
  logic [NPINS-1:0] in_val;
  logic [NPINS-1:0] ctl_oval, ctl_oe, ctl_od, ctl_oinv, ctl_pu;

  gpb_regdec #(.ADDR_W(ADDR_W), .HIGH_BIT(HIGH_BIT)) u_dec (
    .addr (addr),
    .dec  (dec)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [NUM_CTL-1:0][BANK_W-1:0] bctl;
    logic bwe;
    assign bwe = wr_en && dec.hit && (dec.high == 1'(b)) && (dec.sel != CTL_INRD);
    gpb_bank #(.BANK_W(BANK_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (bwe),
      .sel   (dec.sel),
      .wdata (wdata),
      .ctl_q (bctl)
    );
    for (genvar c = 0; c < NUM_CTL; c++) begin : g_flat
      assign ctl_all[c][b*BANK_W +: BANK_W] = bctl[c];
    end
  end

  assign ctl_oval = ctl_all[CTL_OVAL];
  assign ctl_oe   = ctl_all[CTL_OE];
  assign ctl_od   = ctl_all[CTL_OD];
  assign ctl_oinv = ctl_all[CTL_OINV];
  assign ctl_pu   = ctl_all[CTL_PU];

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpb_pin u_pin (
      .clk     (clk),
      .rst     (rst),
      .oval    (ctl_all[CTL_OVAL][p]),
      .oe      (ctl_all[CTL_OE][p]),
      .od      (ctl_all[CTL_OD][p]),
      .ie      (ctl_all[CTL_IE][p]),
      .iinv    (ctl_all[CTL_IINV][p]),
      .oinv    (ctl_all[CTL_OINV][p]),
      .pu      (ctl_all[CTL_PU][p]),
      .pd      (ctl_all[CTL_PD][p]),
      .pad_in  (pad_in[p]),
      .pad_out (pad_out[p]),
      .pad_oe  (pad_oe[p]),
      .pad_pu  (pad_pu[p]),
      .pad_pd  (pad_pd[p]),
      .in_val  (in_val[p])
    );
  end

  // Registered read path: bank half in the low bits, zero above.
  logic [BANK_W-1:0] rd_bits;
  logic [NPINS-1:0]  rd_word;

  always_comb begin
    rd_bits = '0;
    rd_word = '0;
    if (dec.hit) begin
      if (dec.sel == CTL_INRD) rd_word = in_val;
      else                     rd_word = ctl_all[dec.sel[2:0]];
      rd_bits = dec.high ? rd_word[NPINS-1:BANK_W] : rd_word[BANK_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rdata    <= rd_en ? {{(DATA_W-BANK_W){1'b0}}, rd_bits} : '0;
    end
  end
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker #(
  parameter int BANK_W = 16,
  parameter int ADDR_W = 8,
  parameter int NPINS  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              rd_valid,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pad_pu,
  input logic [NPINS-1:0]  ctl_oval,
  input logic [NPINS-1:0]  ctl_oe,
  input logic [NPINS-1:0]  ctl_od,
  input logic [NPINS-1:0]  ctl_oinv,
  input logic [NPINS-1:0]  ctl_pu
);
  AST_RD_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rdata[DATA_W-1:BANK_W] == '0)); // R6

  AST_RD_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R6

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(ctl_oval) && $stable(ctl_oe) && $stable(ctl_od) && $stable(ctl_pu))); // R2

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == '0) |=> ((ctl_oval[BANK_W-1:0] & $past(wdata[DATA_W-1:BANK_W])) == '0)); // R4

  AST_OE_SUBSET: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe & ~$past(ctl_oe)) == '0)); // R7

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
    ((pad_out & $past(ctl_od)) == '0)); // R8

  AST_PP_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (((pad_out ^ $past(ctl_oval) ^ $past(ctl_oinv)) & ~$past(ctl_od)) == '0)); // R7

  AST_PULLUP_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    pad_pu == $past(ctl_pu)); // R10
endmodule

bind pinbank_gpio gpb_checker #(
  .BANK_W(BANK_W), .ADDR_W(ADDR_W), .NPINS(NPINS), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/tb_pinbank_gpio.sv
module tb_pinbank_gpio;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, pad_pu, pad_pd;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  pinbank_gpio dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
    n_checks++;
    if (rd_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL R6: rd_valid actual %b expected 1", rd_valid);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 pad_pu", pad_pu | pad_pd, 32'h0);
    do_read(8'h04, d); check("R1 oe reg", d, 32'h0);
    do_read(8'h98, d); check("R1 high pu reg", d, 32'h0);
  endtask

  task automatic t_set_clear();
    logic [31:0] d;
    do_write(8'h04, 32'h0000_00A5);
    do_read(8'h04, d); check("R2 set", d, 32'h0000_00A5);
    do_write(8'h04, 32'h0001_0000);
    do_read(8'h04, d); check("R3 clear", d, 32'h0000_00A4);
    do_write(8'h04, 32'h0004_000C);
    do_read(8'h04, d); check("R4 clear wins", d, 32'h0000_00A8);
    do_write(8'h04, 32'h0102_0102);
    do_read(8'h04, d); check("R4 both bits", d, 32'h0000_00A8);
    do_read(8'h08, d); check("R2 other reg untouched", d, 32'h0);
  endtask

  task automatic t_high_bank();
    logic [31:0] d;
    do_write(8'h84, 32'h0000_8001);
    do_read(8'h84, d); check("R5 high read", d, 32'h0000_8001);
    do_read(8'h04, d); check("R5 low untouched", d, 32'h0000_00A8);
    check("R5 pad_oe", pad_oe, 32'h8001_00A8);
  endtask

  task automatic t_pushpull();
    logic [31:0] d;
    do_write(8'h00, 32'h0000_000F);
    do_write(8'h14, 32'h0000_0003);
    do_write(8'h80, 32'h0000_0001);
    settle();
    check("R7 pad_out", pad_out, 32'h0001_000C);
    check("R7 pad_oe", pad_oe, 32'h8001_00A8);
    do_read(8'h00, d); check("R6 oval read", d, 32'h0000_000F);
  endtask

  task automatic t_latency();
    do_write(8'h00, 32'h0000_0010);
    check("R7 one-cycle lag", pad_out, 32'h0001_000C);
    settle();
    check("R7 after lag", pad_out, 32'h0001_001C);
    do_write(8'h00, 32'h0010_0000);
    settle();
  endtask

  task automatic t_opendrain();
    do_write(8'h08, 32'h0000_00FF);
    settle();
    check("R8 pad_out low", pad_out, 32'h0001_0000);
    check("R8 pad_oe", pad_oe, 32'h8001_00A0);
    do_write(8'h08, 32'h00FF_0000);
    settle();
    check("R8 released", pad_oe, 32'h8001_00A8);
  endtask

  task automatic t_pulls();
    do_write(8'h18, 32'h0000_0011);
    do_write(8'h9C, 32'h0000_0300);
    settle();
    check("R10 pad_pu", pad_pu, 32'h0000_0011);
    check("R10 pad_pd", pad_pd, 32'h0300_0000);
  endtask

  task automatic t_input();
    logic [31:0] d;
    @(negedge clk); pad_in = 32'h1234_5678;
    do_write(8'h0C, 32'h0000_00FF);
    do_write(8'h10, 32'h0000_000F);
    repeat (5) settle();
    do_read(8'h20, d); check("R9 low readback", d, 32'h0000_0077);
    do_read(8'hA0, d); check("R9 high disabled", d, 32'h0);
    do_write(8'h8C, 32'h0000_FFFF);
    repeat (2) settle();
    do_read(8'hA0, d); check("R9 high enabled", d, 32'h0000_1234);
    @(negedge clk); pad_in = 32'h1234_5679;
    do_read(8'h20, d); check("R9 sync delay", d, 32'h0000_0077);
    repeat (4) settle();
    do_read(8'h20, d); check("R9 after sync", d, 32'h0000_0076);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    do_write(8'h20, 32'h0000_FFFF);
    do_write(8'h24, 32'h0000_FFFF);
    do_write(8'h05, 32'h0000_FFFF);
    do_write(8'h00, 32'h0000_0000);
    do_write(8'h04, 32'h0000_0000);
    do_read(8'h04, d); check("R11 oe unchanged", d, 32'h0000_00A8);
    do_read(8'h24, d); check("R11 unmapped reads 0", d, 32'h0);
    do_read(8'h20, d); check("R11 readback unchanged", d, 32'h0000_0076);
    settle();
    check("R11 pads unchanged", pad_oe, 32'h8001_00A8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_set_clear();
    t_high_bank();
    t_pushpull();
    t_latency();
    t_opendrain();
    t_pulls();
    t_input();
    t_ignored();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule